// File: doc/BRIEF.md
# Floating-Point Control and Status Word Unit

This block holds the 32-bit control and status word of a floating-point unit. After each arithmetic operation it takes the set of exceptions that operation raised. It overwrites the per-operation cause field with that set and ORs the same set into the sticky flag field. It compares the cause field against the enable field and raises a trap request while any enabled cause is pending. A compare operation can write one of eight condition-code bits, chosen by a 3-bit index.

Software reaches the word through a control-register port. The read side is combinational and decodes a 5-bit register index: index 31 returns the status word, and every other index (including the read-only revision register at index 0) returns zero. A write to index 31 changes only the software-owned fields. The datapath uses the `wb_block` output to drop the result writeback of an operation whose exceptions are enabled. The rounding mode, flush-to-zero bit and condition codes are driven out as plain outputs.

There is no sequencer in this block. It has one state register, with one combinational next-value path built from a write-merge stage followed by an operation-update stage. A write and an operation in the same cycle are therefore ordered as write first, update second.

Top module: `fcsr_unit`

## Requirements
- R1: After reset the status word reads 0x00000000, and `rnd_mode`, `flush_zero`, `cc_vec` and `trap_req` are all zero.
- R2: When `op_valid` is high, at the next edge the cause field (bits 17:12) becomes {0, `op_exc`}. The previous causes are discarded. `op_exc` bit order is inexact 0, underflow 1, overflow 2, divide-by-zero 3, invalid 4.
- R3: When `op_valid` is high, each set `op_exc` bit also sets the matching flag in bits 6:2. Flags are never cleared except by a software write.
- R4: `trap_req` is high exactly when some cause bit k+12 (k = 0..4) and its enable bit k+7 are both set in the stored word.
- R5: `wb_block` is high in the same cycle as an operation whose `op_exc` meets an enable bit. While it is high, that operation's condition-code write is dropped.
- R6: A write to index 31 changes only bit 24 (flush), bits 11:7 (enables), bits 6:2 (flags) and bits 1:0 (rounding mode). All other bits keep their values.
- R7: A software write that sets an enable bit over a pending cause bit raises `trap_req` at the next edge.
- R8: `rnd_mode` is bits 1:0, encoded 0 nearest, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R9: `ctl_rd_data` shows the word in the same cycle for index 31 and zero for any other index. Writes to any other index change nothing.
- R10: A condition-code write with index 0 targets bit 23, and index k = 1..7 targets bit 24+k. `cc_vec[k]` mirrors condition code k.
- R11: When a software write and an operation fall in the same cycle, the operation is applied after the write. Its flags OR into the written flags, and its trap test uses the written enables.
- R12: `flush_zero` is bit 24 of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An arithmetic operation completes this cycle |
| op_exc | input | 5 | Exceptions raised by that operation |
| op_cc_we | input | 1 | The operation writes a condition code |
| op_cc_idx | input | 3 | Condition-code index |
| op_cc_val | input | 1 | Condition-code value |
| ctl_wr_en | input | 1 | Control-register write strobe |
| ctl_wr_idx | input | 5 | Control-register write index |
| ctl_wr_data | input | 32 | Control-register write data |
| ctl_rd_idx | input | 5 | Control-register read index |
| ctl_rd_data | output | 32 | Control-register read data, combinational |
| rnd_mode | output | 2 | Current rounding mode |
| flush_zero | output | 1 | Flush-to-zero control |
| cc_vec | output | 8 | Condition codes 0..7 |
| trap_req | output | 1 | Enabled cause pending in the stored word |
| wb_block | output | 1 | Suppress this operation's writeback |

## Verification
Two timings apply. `wb_block` and `ctl_rd_data` are combinational and are due in the cycle of the stimulus. The bench samples them one nanosecond after driving, well before the next rising edge. The stored word, `trap_req`, `rnd_mode`, `flush_zero` and `cc_vec` are due one edge after the write or operation, so the bench drives on a falling edge and compares on the following falling edge. The reference word in the bench steps forward by the same write-then-update order at each edge.

// File: rtl/fcsr_pkg.sv
`timescale 1ns/1ps
package fcsr_pkg;
    localparam int CSR_W      = 32;
    localparam int EXC_W      = 5;
    localparam int CC_N       = 8;
    localparam int CC_IDX_W   = $clog2(CC_N);
    localparam int CREG_IDX_W = 5;
    localparam int RM_W       = 2;

    // field positions (the trap rule depends on EN/CAUSE spacing)
    localparam int RM_LSB     = 0;
    localparam int FLAG_LSB   = 2;
    localparam int EN_LSB     = FLAG_LSB + EXC_W;
    localparam int CAUSE_LSB  = EN_LSB + EXC_W;
    localparam int CAUSE_W    = EXC_W + 1;
    localparam int CC0_BIT    = 23;
    localparam int FLUSH_BIT  = 24;
    localparam int CCHI_LSB   = 25;

    localparam int CSR_SEL    = 31;
    localparam int REV_SEL    = 0;

    function automatic logic [CSR_W-1:0] sw_mask();
        logic [CSR_W-1:0] m;
        m = '0;
        for (int i = 0; i < RM_W; i++)  m[RM_LSB + i]   = 1'b1;
        for (int i = 0; i < EXC_W; i++) m[FLAG_LSB + i] = 1'b1;
        for (int i = 0; i < EXC_W; i++) m[EN_LSB + i]   = 1'b1;
        m[FLUSH_BIT] = 1'b1;
        return m;
    endfunction

    function automatic int cc_pos(input int k);
        return (k == 0) ? CC0_BIT : (CCHI_LSB + k - 1);
    endfunction
endpackage

// File: rtl/fcsr_wmerge.sv
`timescale 1ns/1ps
module fcsr_wmerge
    import fcsr_pkg::*;
(
    input  logic [CSR_W-1:0] cur_word,
    input  logic             wr_hit,
    input  logic [CSR_W-1:0] wr_data,
    output logic [CSR_W-1:0] merged
);
    localparam logic [CSR_W-1:0] MASK = sw_mask();

    always_comb begin
        if (wr_hit) merged = (cur_word & ~MASK) | (wr_data & MASK);
        else        merged = cur_word;
    end
endmodule

// File: rtl/fcsr_opupd.sv
`timescale 1ns/1ps
module fcsr_opupd
    import fcsr_pkg::*;
(
    input  logic [CSR_W-1:0]    base_word,
    input  logic                op_valid,
    input  logic [EXC_W-1:0]    op_exc,
    input  logic                op_cc_we,
    input  logic [CC_IDX_W-1:0] op_cc_idx,
    input  logic                op_cc_val,
    output logic [CSR_W-1:0]    next_word,
    output logic                wb_block
);
    logic [CSR_W-1:0] cc_sel;
    logic [EXC_W-1:0] en_f;

    // one-hot placement of the selected condition-code bit
    generate
        for (genvar k = 0; k < CC_N; k++) begin : g_ccdec
            assign cc_sel[cc_pos(k)] = (op_cc_idx == CC_IDX_W'(k));
        end
        for (genvar b = 0; b < CSR_W; b++) begin : g_ccfill
            if (!((b == CC0_BIT) || (b >= CCHI_LSB && b < CCHI_LSB + CC_N - 1))) begin : g_zero
                assign cc_sel[b] = 1'b0;
            end
        end
    endgenerate

    assign en_f     = base_word[EN_LSB +: EXC_W];
    assign wb_block = op_valid && ((op_exc & en_f) != '0);

    always_comb begin
        next_word = base_word;
        if (op_valid) begin
            next_word[CAUSE_LSB +: CAUSE_W] = {1'b0, op_exc};
            next_word[FLAG_LSB +: EXC_W]    = base_word[FLAG_LSB +: EXC_W] | op_exc;
            if (op_cc_we && !wb_block) begin
                if (op_cc_val) next_word = next_word | cc_sel;
                else           next_word = next_word & ~cc_sel;
            end
        end
    end
endmodule

// File: rtl/fcsr_rdmux.sv
`timescale 1ns/1ps
module fcsr_rdmux
    import fcsr_pkg::*;
#(
    parameter logic [CSR_W-1:0] REV_VAL = '0
) (
    input  logic [CREG_IDX_W-1:0] rd_idx,
    input  logic [CSR_W-1:0]      csr_word,
    output logic [CSR_W-1:0]      rd_data
);
    always_comb begin
        if (rd_idx == CREG_IDX_W'(CSR_SEL))      rd_data = csr_word;
        else if (rd_idx == CREG_IDX_W'(REV_SEL)) rd_data = REV_VAL;
        else                                     rd_data = '0;
    end
endmodule

// File: rtl/fcsr_unit.sv
`timescale 1ns/1ps
module fcsr_unit
    import fcsr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  logic [EXC_W-1:0]      op_exc,
    input  logic                  op_cc_we,
    input  logic [CC_IDX_W-1:0]   op_cc_idx,
    input  logic                  op_cc_val,
    input  logic                  ctl_wr_en,
    input  logic [CREG_IDX_W-1:0] ctl_wr_idx,
    input  logic [CSR_W-1:0]      ctl_wr_data,
    input  logic [CREG_IDX_W-1:0] ctl_rd_idx,
    output logic [CSR_W-1:0]      ctl_rd_data,
    output logic [RM_W-1:0]       rnd_mode,
    output logic                  flush_zero,
    output logic [CC_N-1:0]       cc_vec,
    output logic                  trap_req,
    output logic                  wb_block
);
    logic [CSR_W-1:0] csr_q;
    logic [CSR_W-1:0] after_wr;
    logic [CSR_W-1:0] csr_d;
    logic             wr_hit;

    assign wr_hit = ctl_wr_en && (ctl_wr_idx == CREG_IDX_W'(CSR_SEL));

    fcsr_wmerge u_wmerge (
        .cur_word (csr_q),
        .wr_hit   (wr_hit),
        .wr_data  (ctl_wr_data),
        .merged   (after_wr)
    );

    fcsr_opupd u_opupd (
        .base_word (after_wr),
        .op_valid  (op_valid),
        .op_exc    (op_exc),
        .op_cc_we  (op_cc_we),
        .op_cc_idx (op_cc_idx),
        .op_cc_val (op_cc_val),
        .next_word (csr_d),
        .wb_block  (wb_block)
    );

    fcsr_rdmux #(.REV_VAL('0)) u_rdmux (
        .rd_idx   (ctl_rd_idx),
        .csr_word (csr_q),
        .rd_data  (ctl_rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) csr_q <= '0;
        else        csr_q <= csr_d;
    end

    assign rnd_mode   = csr_q[RM_LSB +: RM_W];
    assign flush_zero = csr_q[FLUSH_BIT];
    assign trap_req   = (csr_q[CAUSE_LSB +: EXC_W] & csr_q[EN_LSB +: EXC_W]) != '0;

    generate
        for (genvar k = 0; k < CC_N; k++) begin : g_ccout
            assign cc_vec[k] = csr_q[cc_pos(k)];
        end
    endgenerate

    // R2: causes replaced by the operation's set
    p_cause_replace_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> csr_q[CAUSE_LSB +: CAUSE_W] == {1'b0, $past(op_exc)});

    // R3: flags only clear through a software write
    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> ($past(csr_q[FLAG_LSB +: EXC_W]) & ~csr_q[FLAG_LSB +: EXC_W]) == '0);

    // R4: a trap always has a cause behind it
    p_trap_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> csr_q[CAUSE_LSB +: EXC_W] != '0);

    // R5: blocked operation leaves condition codes alone
    p_cc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_block |=> cc_vec == $past(cc_vec));

    // R6: software write leaves causes and condition codes alone
    p_wr_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !op_valid) |=> (csr_q[23:CAUSE_LSB] == $past(csr_q[23:CAUSE_LSB]))
                                  && (csr_q[CSR_W-1:CCHI_LSB] == $past(csr_q[CSR_W-1:CCHI_LSB])));

    // R7: enabling a pending cause traps next cycle
    p_enable_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !op_valid && ((ctl_wr_data[EN_LSB +: EXC_W] & csr_q[CAUSE_LSB +: EXC_W]) != '0))
        |=> trap_req);

    // R9: other indices read zero
    p_rd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd_idx != CREG_IDX_W'(CSR_SEL)) |-> ctl_rd_data == '0);
endmodule

// File: tb/fcsr_unit_tb.sv
`timescale 1ns/1ps
module fcsr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_exc = '0;
    logic        op_cc_we = 1'b0;
    logic [2:0]  op_cc_idx = '0;
    logic        op_cc_val = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [4:0]  ctl_wr_idx = '0;
    logic [31:0] ctl_wr_data = '0;
    logic [4:0]  ctl_rd_idx = 5'd31;
    logic [31:0] ctl_rd_data;
    logic [1:0]  rnd_mode;
    logic        flush_zero;
    logic [7:0]  cc_vec;
    logic        trap_req;
    logic        wb_block;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;
    logic [31:0] m;   // reference word

    always #2.5 clk = ~clk;

    fcsr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_exc(op_exc),
        .op_cc_we(op_cc_we), .op_cc_idx(op_cc_idx), .op_cc_val(op_cc_val),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_idx(ctl_wr_idx), .ctl_wr_data(ctl_wr_data),
        .ctl_rd_idx(ctl_rd_idx), .ctl_rd_data(ctl_rd_data), .rnd_mode(rnd_mode),
        .flush_zero(flush_zero), .cc_vec(cc_vec), .trap_req(trap_req), .wb_block(wb_block)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic int ccp(input int k);
        return (k == 0) ? 23 : 24 + k;
    endfunction

    function automatic logic [7:0] exp_cc(input logic [31:0] w);
        logic [7:0] c;
        for (int k = 0; k < 8; k++) c[k] = w[ccp(k)];
        return c;
    endfunction

    // compare all registered outputs against the reference (at a falling edge)
    task automatic check_all(input string req);
        chk({req, " word"}, ctl_rd_data, m);
        chk({req, " trap"}, 32'(trap_req), 32'(|(m[16:12] & m[11:7])));
        chk({req, " rm"}, 32'(rnd_mode), 32'(m[1:0]));
        chk({req, " flush"}, 32'(flush_zero), 32'(m[24]));
        chk({req, " cc"}, 32'(cc_vec), 32'(exp_cc(m)));
    endtask

    // one cycle: drive at falling edge, check wb_block, step model at edge
    task automatic cyc(input bit we, input logic [4:0] widx, input logic [31:0] wd,
                       input bit ov, input logic [4:0] ex,
                       input bit cwe, input logic [2:0] ci, input bit cv, input string req);
        bit blk;
        ctl_wr_en = we; ctl_wr_idx = widx; ctl_wr_data = wd;
        op_valid = ov; op_exc = ex; op_cc_we = cwe; op_cc_idx = ci; op_cc_val = cv;
        if (we && widx == 5'd31) m = (m & ~32'h01000FFF) | (wd & 32'h01000FFF);
        blk = ov && ((ex & m[11:7]) != 0);
        #1;
        chk({req, " wb_block"}, 32'(wb_block), 32'(blk));
        if (ov) begin
            m[17:12] = {1'b0, ex};
            m[6:2]   = m[6:2] | ex;
            if (cwe && !blk) m[ccp(int'(ci))] = cv;
        end
        @(negedge clk);
        ctl_wr_en = 0; op_valid = 0; op_cc_we = 0;
    endtask

    initial begin
        m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R8: rounding-mode encodings pass through
        for (int r = 0; r < 4; r++) begin
            cyc(1, 5'd31, 32'(r), 0, 0, 0, 0, 0, "R8");
            check_all("R8 rounding mode");
        end

        // R6: write mask
        cyc(1, 5'd31, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R6");
        chk("R6 masked write", ctl_rd_data, 32'h0100_0FFF);
        check_all("R6");
        // R12: flush bit
        cyc(1, 5'd31, 32'h0100_0000, 0, 0, 0, 0, 0, "R12");
        chk("R12 flush", 32'(flush_zero), 32'd1);
        cyc(1, 5'd31, 32'h0, 0, 0, 0, 0, 0, "R12");
        chk("R12 flush clear", 32'(flush_zero), 32'd0);

        // R9: other indices
        cyc(1, 5'd7, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R9");
        check_all("R9 write other index ignored");
        ctl_rd_idx = 5'd0; #1;
        chk("R9 revision reads zero", ctl_rd_data, 32'h0);
        ctl_rd_idx = 5'd5; #1;
        chk("R9 other index reads zero", ctl_rd_data, 32'h0);
        ctl_rd_idx = 5'd31; #1;
        chk("R9 csr same cycle", ctl_rd_data, m);
        @(negedge clk);

        // R2 R3 R4 R5 R10 sweep over enable masks and all exception sets
        for (int e = 0; e < 8; e++) begin
            logic [4:0] en;
            case (e)
                0: en = 5'h00; 1: en = 5'h1F; 2: en = 5'h15; 3: en = 5'h0A;
                default: en = 5'(1 << (e - 3));
            endcase
            cyc(1, 5'd31, {20'h0, en, 5'h00, 2'(e)}, 0, 0, 0, 0, 0, "R3 clear");
            check_all("R3 flags cleared by write");
            for (int x = 0; x < 32; x++) begin
                logic [2:0] ci;
                ci = 3'(x + e);
                cyc(0, 0, 0, 1, 5'(x), 1, ci, ~m[ccp(int'(ci))], "R5");
                check_all("R2 R3 R4 R10 op update");
            end
        end

        // R7: enable written over pending cause
        cyc(1, 5'd31, 32'h0, 0, 0, 0, 0, 0, "R7");
        cyc(0, 0, 0, 1, 5'h04, 0, 0, 0, "R7");
        chk("R7 no trap before enable", 32'(trap_req), 32'd0);
        cyc(1, 5'd31, 32'h0000_0200, 0, 0, 0, 0, 0, "R7");
        chk("R7 trap after enable", 32'(trap_req), 32'd1);
        cyc(0, 0, 0, 1, 5'h00, 0, 0, 0, "R7");
        chk("R7 trap cleared by clean op", 32'(trap_req), 32'd0);

        // R11: same-cycle write and operation
        cyc(1, 5'd31, 32'h0, 0, 0, 0, 0, 0, "R11");
        cyc(0, 0, 0, 1, 5'h10, 0, 0, 0, "R11");
        cyc(1, 5'd31, 32'h0, 1, 5'h01, 0, 0, 0, "R11");
        chk("R11 flags written then ORed", 32'(m[6:2]), 32'h01);
        check_all("R11 order");
        cyc(1, 5'd31, 32'h0000_0080, 1, 5'h01, 1, 3'd2, 1, "R11");
        chk("R11 written enable blocks cc", 32'(cc_vec[2]), 32'd0);
        check_all("R11 R5 blocked");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule